// File: doc/BRIEF.md
# Operand Width Extension Unit

This block widens narrow operands to the 32-bit longword that every datapath operation uses. It serves two paths of a 32-bit RISC core. On the load path it receives the 32-bit word returned by data memory, picks the byte or halfword lane named by the low address bits, and sign-extends it; a longword load goes through as it is. On the immediate path it takes the 8-bit literal field of a 16-bit instruction and widens it according to the class of the operation that uses it. Arithmetic and compare-style operations (move-immediate, add, compare-equal) get a sign-extended literal. Logical operations (test, AND, OR, XOR) get a zero-extended literal.

A load whose address does not suit its size raises a misalignment flag, and the data beside it then carries no meaning. By default the outputs are registered, so results appear one clock after the request with a valid bit alongside. Lanes are ordered big-endian: address offset 0 holds the most significant byte of the word. The parameter `REGISTERED` set to 0 gives a purely combinational variant.

Top module: `ext_width_unit`

## Requirements
- R1: For a byte load (size code 2'b00) the lane is picked big-endian by addr_lo: 0 takes bits [31:24], 1 takes [23:16], 2 takes [15:8], 3 takes [7:0].
- R2: For a halfword load (size code 2'b01) addr_lo[1] picks the lane: 0 takes bits [31:16], 1 takes bits [15:0].
- R3: A loaded byte or halfword is sign-extended, so every result bit above the lane repeats the lane's top bit.
- R4: A longword load (size code 2'b10, and the spare code 2'b11 treated the same) with addr_lo of 0 returns the read word unchanged.
- R5: misaligned is 1 for a halfword load with addr_lo[0] set and for a longword load with addr_lo not 0; a byte load never raises it.
- R6: With sel_imm=1 and op_logic=0 (arithmetic or compare class) the result is the 8-bit literal sign-extended to 32 bits.
- R7: With sel_imm=1 and op_logic=1 (logical class) the result is the 8-bit literal zero-extended to 32 bits.
- R8: With sel_imm=1 the read word, addr_lo and size have no effect on the result, and misaligned stays 0.
- R9: In the registered variant, out_valid equals in_valid of the previous cycle, and result and misaligned update only on cycles where in_valid was 1 and hold otherwise.
- R10: While rst_n is low, and for two clocks after it rises, out_valid, result and misaligned are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| rd_word | input | 32 | Word read from data memory |
| addr_lo | input | 2 | Low byte-address bits of the load |
| size | input | 2 | Load size: 00 byte, 01 halfword, 10/11 longword |
| imm8 | input | 8 | Literal field of the instruction |
| sel_imm | input | 1 | 1 selects the immediate path, 0 the load path |
| op_logic | input | 1 | 1 marks a logical-class operation, 0 arithmetic/compare |
| out_valid | output | 1 | Result present |
| result | output | 32 | Widened 32-bit operand |
| misaligned | output | 1 | Load address does not suit its size |

## Verification
The hardest case to reach from the ports is a lane whose top bit is set while the neighbouring lanes hold the opposite pattern, because only then does a wrong lane pick or a wrong extension show up in the upper bits. The stimulus draws read words from patterns that alternate sign bits between lanes as well as from fully random words, and covers all four offsets under every size code. Immediate requests are sent with misaligned-looking addresses and noisy read words to show that the load inputs are ignored, and idle cycles are mixed in to expose a register that fails to hold.

// File: rtl/ext_pkg.sv
package ext_pkg;

  // Load size codes; the spare code behaves as a longword.
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_LONG = 2'b10,
    SZ_SPARE = 2'b11
  } load_size_e;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/ext_load_lane.sv
module ext_load_lane
  import ext_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BYTES = DATA_W / LANE_W,
  localparam int unsigned HALVES = BYTES / 2,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] ext_o,
  output logic              mis_o
);

  logic [LANE_W-1:0] byte_lane [BYTES];
  logic [HALF_W-1:0] half_lane [HALVES];

  // Big-endian: lane 0 is the most significant
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_lane[b] = word_i[DATA_W-1-LANE_W*b -: LANE_W];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_lane[h] = word_i[DATA_W-1-HALF_W*h -: HALF_W];
  end

  logic [LANE_W-1:0] pick_byte;
  logic [HALF_W-1:0] pick_half;

  always_comb begin
    pick_byte = byte_lane[off_i];
    pick_half = half_lane[off_i[OFF_W-1]];
  end

  always_comb begin
    ext_o = word_i;
    mis_o = 1'b0;
    case (load_size_e'(size_i))
      SZ_BYTE: begin
        ext_o = {{(DATA_W-LANE_W){pick_byte[LANE_W-1]}}, pick_byte};
      end
      SZ_HALF: begin
        ext_o = {{(DATA_W-HALF_W){pick_half[HALF_W-1]}}, pick_half};
        mis_o = off_i[0];
      end
      default: begin
        ext_o = word_i;
        mis_o = |off_i;
      end
    endcase
  end

endmodule

// File: rtl/ext_imm_widen.sv
module ext_imm_widen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W = 8,
  localparam int unsigned PAD_W = DATA_W - IMM_W
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              logic_cls_i,
  output logic [DATA_W-1:0] ext_o
);

  logic fill;

  always_comb begin
    // Logical class pads with zero, all others copy the literal's sign
    fill  = logic_cls_i ? 1'b0 : imm_i[IMM_W-1];
    ext_o = {{PAD_W{fill}}, imm_i};
  end

endmodule

// File: rtl/ext_out_stage.sv
module ext_out_stage #(
  parameter int unsigned DATA_W = 32,
  parameter bit REGISTERED = 1'b1,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_mis,
  output logic              out_valid,
  output logic [DATA_W-1:0] q_result,
  output logic              q_mis
);

  if (REGISTERED) begin : g_reg
    logic [SYNC_LEN-1:0] sync_q;
    logic                run;

    // Reset enters at once and leaves on a clock edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
    end
    assign run = sync_q[SYNC_LEN-1];

    logic              vld_d, vld_q;
    logic [DATA_W-1:0] res_d, res_q;
    logic              mis_d, mis_q;
    logic              load_en;

    always_comb begin
      load_en = in_valid;
      vld_d   = in_valid;
      res_d   = load_en ? d_result : res_q;
      mis_d   = load_en ? d_mis : mis_q;
    end

    always_ff @(posedge clk or negedge run) begin
      if (!run) begin
        vld_q <= 1'b0;
        res_q <= '0;
        mis_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        res_q <= res_d;
        mis_q <= mis_d;
      end
    end

    assign out_valid = vld_q;
    assign q_result  = res_q;
    assign q_mis     = mis_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!run)
      out_valid == $past(in_valid)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!run)
      !$past(in_valid) |-> ($stable(q_result) && $stable(q_mis))); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
      !run |-> (!out_valid && q_result == '0 && !q_mis)); // R10
  end else begin : g_comb
    assign out_valid = in_valid;
    assign q_result  = d_result;
    assign q_mis     = d_mis;
  end

endmodule

// File: rtl/ext_width_unit.sv
module ext_width_unit
  import ext_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int unsigned OFF_W = $clog2(DATA_W / LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [OFF_W-1:0]  addr_lo,
  input  logic [1:0]        size,
  input  logic [IMM_W-1:0]  imm8,
  input  logic              sel_imm,
  input  logic              op_logic,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              misaligned
);

  logic [DATA_W-1:0] load_ext;
  logic              load_mis;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] pre_res;
  logic              pre_mis;

  ext_load_lane #(.DATA_W(DATA_W)) u_lane (
    .word_i (rd_word),
    .off_i  (addr_lo),
    .size_i (size),
    .ext_o  (load_ext),
    .mis_o  (load_mis)
  );

  ext_imm_widen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
    .imm_i       (imm8),
    .logic_cls_i (op_logic),
    .ext_o       (imm_ext)
  );

  always_comb begin
    pre_res = sel_imm ? imm_ext : load_ext;
    pre_mis = !sel_imm && load_mis;
  end

  ext_out_stage #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d_result  (pre_res),
    .d_mis     (pre_mis),
    .out_valid (out_valid),
    .q_result  (result),
    .q_mis     (misaligned)
  );

  if (REGISTERED) begin : g_chk
    AST_BYTE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(!sel_imm && size == SZ_BYTE))
      |-> result[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){result[LANE_W-1]}}); // R3
    AST_HALF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !misaligned && $past(!sel_imm && size == SZ_HALF))
      |-> result[DATA_W-1:DATA_W/2] == {(DATA_W/2){result[DATA_W/2-1]}}); // R3
    AST_LONG_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(!sel_imm && size[1] && addr_lo != '0)) |-> misaligned); // R5
    AST_BYTE_NEVER_MIS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(!sel_imm && size == SZ_BYTE)) |-> !misaligned); // R5
    AST_IMM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(sel_imm && !op_logic))
      |-> result == {{(DATA_W-IMM_W){$past(imm8[IMM_W-1])}}, $past(imm8)}); // R6
    AST_IMM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(sel_imm && op_logic))
      |-> result[DATA_W-1:IMM_W] == '0); // R7
    AST_IMM_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(sel_imm)) |-> !misaligned); // R8
  end

endmodule

// File: tb/ext_width_unit_tb_top.sv
module ext_width_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] rd_word;
  logic [1:0]  addr_lo;
  logic [1:0]  size;
  logic [7:0]  imm8;
  logic        sel_imm;
  logic        op_logic;
  logic        out_valid;
  logic [31:0] result;
  logic        misaligned;

  int total;
  int bad;
  bit done;

  ext_width_unit dut_i (
    .clk, .rst_n, .in_valid, .rd_word, .addr_lo, .size,
    .imm8, .sel_imm, .op_logic, .out_valid, .result, .misaligned
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_res(logic [31:0] w, logic [1:0] a,
                                          logic [1:0] s, logic [7:0] im,
                                          logic si, logic lg);
    logic [7:0]  b;
    logic [15:0] h;
    if (si) return lg ? {24'h0, im} : {{24{im[7]}}, im};
    b = 8'((w >> (8 * (3 - a))) & 32'hFF);
    h = a[1] ? w[15:0] : w[31:16];
    case (s)
      2'b00:   return {{24{b[7]}}, b};
      2'b01:   return {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  function automatic logic exp_mis(logic [1:0] a, logic [1:0] s, logic si);
    if (si) return 1'b0;
    case (s)
      2'b00:   return 1'b0;
      2'b01:   return a[0];
      default: return a != 2'b00;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_for(logic [1:0] s, logic si, logic lg);
    if (si) return lg ? "R7/R8" : "R6/R8";
    case (s)
      2'b00:   return "R1/R3";
      2'b01:   return "R2/R3";
      default: return "R4";
    endcase
  endfunction

  // Drive one request at a falling edge, check it at the next falling edge
  task automatic apply(logic [31:0] w, logic [1:0] a, logic [1:0] s,
                       logic [7:0] im, logic si, logic lg);
    logic [31:0] er;
    logic        em;
    in_valid = 1'b1; rd_word = w; addr_lo = a; size = s;
    imm8 = im; sel_imm = si; op_logic = lg;
    er = exp_res(w, a, s, im, si, lg);
    em = exp_mis(a, s, si);
    @(negedge clk);
    check(out_valid == 1'b1, "R9 valid", 32'(out_valid), 32'd1);
    check(misaligned == em, "R5 flag", 32'(misaligned), 32'(em));
    if (!em) check(result == er, tag_for(s, si, lg), result, er);
  endtask

  task automatic idle_cycle();
    logic [31:0] keep_r;
    logic        keep_m;
    keep_r = result;
    keep_m = misaligned;
    in_valid = 1'b0; rd_word = $urandom; addr_lo = 2'($urandom);
    size = 2'($urandom); imm8 = 8'($urandom);
    sel_imm = 1'($urandom); op_logic = 1'($urandom);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 idle valid", 32'(out_valid), 32'd0);
    check(result == keep_r && misaligned == keep_m, "R9 hold",
          result, keep_r);
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    void'($urandom(32'h5EED_0417));
    rst_n = 1'b0; in_valid = 1'b0; rd_word = '0; addr_lo = '0; size = '0;
    imm8 = '0; sel_imm = 1'b0; op_logic = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && result == '0 && !misaligned, "R10 in reset",
          result, 32'd0);
    rst_n = 1'b1;
    in_valid = 1'b1; rd_word = 32'hDEAD_BEEF;
    @(negedge clk);
    check(!out_valid && result == '0, "R10 after release", result, 32'd0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    // Directed: byte lanes with alternating signs (R1, R3)
    for (int a = 0; a < 4; a++) apply(32'h80_7F_80_7F, 2'(a), 2'b00, 8'h00, 0, 0);
    for (int a = 0; a < 4; a++) apply(32'h7F_80_7F_80, 2'(a), 2'b00, 8'h00, 0, 0);
    // Directed: halfwords and misaligned halves (R2, R5)
    for (int a = 0; a < 4; a++) apply(32'h8001_7FFE, 2'(a), 2'b01, 8'h00, 0, 0);
    // Directed: longwords with both size codes, all offsets (R4, R5)
    for (int a = 0; a < 4; a++) apply(32'hCAFE_F00D, 2'(a), 2'b10, 8'h00, 0, 0);
    for (int a = 0; a < 4; a++) apply(32'h1234_5678, 2'(a), 2'b11, 8'h00, 0, 0);
    // Directed immediates at sign boundary (R6, R7, R8)
    apply(32'hFFFF_FFFF, 2'b11, 2'b01, 8'h80, 1, 0);
    apply(32'hFFFF_FFFF, 2'b01, 2'b10, 8'h80, 1, 1);
    apply(32'h0000_0000, 2'b11, 2'b10, 8'h7F, 1, 0);
    apply(32'hA5A5_A5A5, 2'b10, 2'b00, 8'hFF, 1, 1);
    idle_cycle();

    // Random mix with idle gaps
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      case ($urandom_range(2, 0))
        0: w = 32'h8080_8080 ^ ($urandom & 32'h7F7F_7F7F);
        1: w = 32'h7F7F_7F7F & $urandom;
        default: w = $urandom;
      endcase
      if ($urandom_range(4, 0) == 0) idle_cycle();
      else apply(w, 2'($urandom), 2'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule